// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Channel

This block sends stereo audio out on a three-wire I2S link: a bit clock, a word-select line and a serial data line. A host pushes left/right sample pairs into an eight-entry queue through a one-cycle write strobe. One pair is copied into a pair of holding registers. The serializer loads the left holding word and then the right holding word into a shift register, and clocks each out MSB first on a bit clock derived from the system clock.

Each pair is fetched from the queue at the moment the right word enters the shift register. If the queue is empty at that moment, nothing is taken from it and the holding registers keep what they have. The next frame then repeats those samples, which are zero after reset and otherwise the last pair sent. A sticky underflow flag reports this. A write to a full queue is dropped and sets a sticky overflow flag. The queue level is visible through the empty, half-empty and full flags.

Top module: `i2s_stereo_tx`

## Requirements
- R1: During and after reset, sck, ws and sd are 0, st_empty and st_half are 1, and st_full, st_overflow and st_underflow are 0.
- R2: The queue holds up to 8 pairs. st_empty is 1 only at 0 pairs, st_half is 1 at 4 or fewer pairs, and st_full is 1 at exactly 8 pairs. The flags follow a write on the clock edge that accepts it.
- R3: A write while st_full is 1 is dropped, so its pair is never sent. It sets st_overflow on the next edge, and st_overflow then stays 1 until reset.
- R4: While enable is 0, sck is held at 0. While enable is 1, sck toggles every DIV_HALF system clocks, so one bit lasts 2*DIV_HALF clocks.
- R5: A frame is 32 bits: a 16-bit left word, then a 16-bit right word, each sent MSB first. ws is 0 for the left word and 1 for the right word, and it changes one bit before the word's MSB. sd and ws change only on falling sck edges, so they are valid on the rising edges.
- R6: If the queue holds data when enable rises, the first frame carries the oldest pair. Each later frame carries the next pair, in write order.
- R7: Enabling with an empty queue right after reset sends zero samples and takes nothing from the queue.
- R8: When the right word of a frame is loaded and the queue is empty, st_underflow becomes 1 and the next frame repeats the same left/right pair.
- R9: st_underflow returns to 0 on the edge after a pair is accepted into the queue, or on the edge after enable is 0.
- R10: Enabling again with an empty queue first sends the last pair that was sent before the channel was disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel run control |
| wr_en | input | 1 | Write strobe for one stereo pair |
| wr_left | input | 16 | Left sample to write |
| wr_right | input | 16 | Right sample to write |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 = left |
| sd | output | 1 | Serial data, MSB first |
| st_empty | output | 1 | Queue holds no pairs |
| st_half | output | 1 | Queue holds 4 pairs or fewer |
| st_full | output | 1 | Queue holds 8 pairs |
| st_overflow | output | 1 | Sticky: a write hit a full queue |
| st_underflow | output | 1 | Fetch found the queue empty |

## Verification
The embedded properties check the following on every cycle:
- the queue level never goes past its depth;
- a write to a full queue leaves the level unchanged, and a fetch from an empty queue leaves the read pointer unchanged;
- sck stays low when the channel is off;
- sd and ws move only after a falling bit-clock edge;
- overflow is sticky once set;
- a disabled channel clears underflow.

Some behaviours can only be shown by the scenarios, because they depend on whole-frame content. These are the ordering of pairs through the queue, zero output after reset, the replay of the held pair after an underflow and after re-enable, and the two-frame latency of a pair written after an underflow. The bench checks them with its own I2S receiver.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

    localparam int SAMPLE_W = 16;
    localparam int SLOTS    = 2 * SAMPLE_W;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    // Word select is high from the last left bit up to the bit before the
    // last right bit, which gives the one-bit lead of the I2S format.
    function automatic logic ws_for_slot(input int slot);
        return (slot >= SAMPLE_W - 1) && (slot <= SLOTS - 2);
    endfunction

    function automatic int half_mark(input int depth);
        return depth / 2;
    endfunction

endpackage

// File: rtl/i2stx_fifo.sv
module i2stx_fifo
    import i2stx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  pair_t push_data,
    input  logic  pop,
    output pair_t head,
    output logic  empty,
    output logic  half,
    output logic  full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    pair_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign half    = (count <= CW'(half_mark(DEPTH)));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R2: level bounded by depth
    a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3: a write into a full queue is dropped
    a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

    // R8: a fetch from an empty queue leaves the read pointer alone
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> $stable(rd_ptr));

endmodule

// File: rtl/i2stx_serial.sv
module i2stx_serial
    import i2stx_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  q_empty,
    input  pair_t q_head,
    output logic  fetch,
    output logic  fetch_miss,
    output logic  sck,
    output logic  ws,
    output logic  sd
);
    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int SW = $clog2(SLOTS);

    logic          run_q;
    logic          sck_q;
    logic [DW-1:0] div_q;
    logic [SW-1:0] slot_q;
    sample_t       shreg;
    pair_t         hold;

    logic tick, fall, mid, wrap, start;

    assign start      = enable && !run_q;
    assign tick       = run_q && (div_q == DW'(DIV_HALF - 1));
    assign fall       = tick && sck_q;
    assign mid        = fall && (slot_q == SW'(SAMPLE_W - 1));
    assign wrap       = fall && (slot_q == SW'(SLOTS - 1));
    assign fetch      = (start || mid) && enable;
    assign fetch_miss = mid && enable && q_empty;

    assign sck = sck_q;
    assign ws  = run_q && ws_for_slot(int'(slot_q));
    assign sd  = run_q && shreg[SAMPLE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            sck_q  <= 1'b0;
            div_q  <= '0;
            slot_q <= '0;
            shreg  <= '0;
            hold   <= '0;
        end else if (!enable) begin
            run_q  <= 1'b0;
            sck_q  <= 1'b0;
            div_q  <= '0;
            slot_q <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            sck_q  <= 1'b0;
            div_q  <= '0;
            slot_q <= '0;
            if (!q_empty) begin
                hold  <= q_head;
                shreg <= q_head.left;
            end else begin
                shreg <= hold.left;
            end
        end else begin
            if (tick) begin
                div_q <= '0;
                sck_q <= ~sck_q;
            end else begin
                div_q <= div_q + DW'(1);
            end
            if (fall) begin
                slot_q <= wrap ? '0 : slot_q + SW'(1);
                if (mid) begin
                    shreg <= hold.right;
                    if (!q_empty) hold <= q_head;
                end else if (wrap) begin
                    shreg <= hold.left;
                end else begin
                    shreg <= shreg << 1;
                end
            end
        end
    end

    // R4: bit clock parked low while disabled
    a_r4_sck_idle: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !sck);

    // R5: line changes only after a falling bit-clock edge
    a_r5_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && !($past(sck_q) && !sck_q)) |-> ($stable(sd) && $stable(ws)));

endmodule

// File: rtl/i2s_stereo_tx.sv
module i2s_stereo_tx
    import i2stx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_HALF   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_left,
    input  logic [SAMPLE_W-1:0] wr_right,
    output logic                sck,
    output logic                ws,
    output logic                sd,
    output logic                st_empty,
    output logic                st_half,
    output logic                st_full,
    output logic                st_overflow,
    output logic                st_underflow
);
    pair_t wr_pair, head;
    logic  fetch, fetch_miss;
    logic  ovf_q, udf_q;

    assign wr_pair = '{left: wr_left, right: wr_right};

    i2stx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en),
        .push_data (wr_pair),
        .pop       (fetch),
        .head      (head),
        .empty     (st_empty),
        .half      (st_half),
        .full      (st_full)
    );

    i2stx_serial #(.DIV_HALF(DIV_HALF)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .q_empty    (st_empty),
        .q_head     (head),
        .fetch      (fetch),
        .fetch_miss (fetch_miss),
        .sck        (sck),
        .ws         (ws),
        .sd         (sd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (wr_en && st_full) ovf_q <= 1'b1;
            if (!enable || (wr_en && !st_full)) udf_q <= 1'b0;
            else if (fetch_miss)                udf_q <= 1'b1;
        end
    end

    assign st_overflow  = ovf_q;
    assign st_underflow = udf_q;

    // R3: overflow is sticky
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        st_overflow |=> st_overflow);

    // R3: writing into a full queue raises overflow
    a_r3_ovf_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && st_full) |=> st_overflow);

    // R9: a disabled channel shows no underflow
    a_r9_udf_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !st_underflow);

endmodule

// File: tb/i2s_stereo_tx_test.sv
module i2s_stereo_tx_test;
    localparam int W   = 16;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic wr_en = 1'b0;
    logic [W-1:0] wr_left = '0, wr_right = '0;
    logic sck, ws, sd, st_empty, st_half, st_full, st_overflow, st_underflow;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    i2s_stereo_tx #(.FIFO_DEPTH(8), .DIV_HALF(DIV)) uut (
        .clk(clk), .rst(rst), .enable(enable), .wr_en(wr_en),
        .wr_left(wr_left), .wr_right(wr_right),
        .sck(sck), .ws(ws), .sd(sd),
        .st_empty(st_empty), .st_half(st_half), .st_full(st_full),
        .st_overflow(st_overflow), .st_underflow(st_underflow)
    );

    // independent I2S receiver
    logic [W-1:0] rx_sh = '0, cur_left = '0;
    logic [W-1:0] pl [64];
    logic [W-1:0] pr [64];
    int  np = 0;
    logic ws_prev = 1'b0, sck_prev = 1'b0, seen_rise = 1'b0;
    int  since = 0, bad_per = 0, n_per = 0;

    always @(negedge clk) begin
        if (sck && !sck_prev) begin
            if (seen_rise) begin
                n_per++;
                if (since != 2 * DIV) bad_per++;
            end
            seen_rise = 1'b1;
            since = 0;
            rx_sh = {rx_sh[W-2:0], sd};
            if (ws != ws_prev) begin
                if (!ws_prev) cur_left = rx_sh;
                else if (np < 64) begin
                    pl[np] = cur_left;
                    pr[np] = rx_sh;
                    np++;
                end
            end
            ws_prev = ws;
        end
        sck_prev = sck;
        since++;
    end

    function automatic logic [W-1:0] lval(input int i);
        return 16'h8001 ^ W'(i * 16'h1357);
    endfunction
    function automatic logic [W-1:0] rval(input int i);
        return 16'h4002 + W'(i * 16'h0F0F);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rx_clear();
        np = 0; ws_prev = 1'b0; seen_rise = 1'b0; rx_sh = '0; cur_left = '0;
    endtask

    task automatic write_pair(input logic [W-1:0] l, input logic [W-1:0] r);
        wr_left = l; wr_right = r; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_pairs(input int n, input string req);
        int guard = 0;
        while (np < n && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check({req, " frames received"}, 32'(np >= n), 32'd1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 sck", 32'(sck), 0);
        check("R1 ws", 32'(ws), 0);
        check("R1 sd", 32'(sd), 0);
        check("R1 empty", 32'(st_empty), 1);
        check("R1 half", 32'(st_half), 1);
        check("R1 full", 32'(st_full), 0);
        check("R1 overflow", 32'(st_overflow), 0);
        check("R1 underflow", 32'(st_underflow), 0);
    endtask

    task automatic t_zero_start();
        rx_clear();
        enable = 1'b1;
        wait_pairs(2, "R7");
        for (int i = 0; i < 2; i++) begin
            check("R7 left zero", 32'(pl[i]), 0);
            check("R7 right zero", 32'(pr[i]), 0);
        end
        @(negedge clk);
        check("R8 underflow set", 32'(st_underflow), 1);
        check("R7 queue untouched", 32'(st_empty), 1);
        step();
        enable = 1'b0;
        step();
        @(negedge clk);
        check("R9 disable clears underflow", 32'(st_underflow), 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R4 sck idle", 32'(sck), 0);
        end
    endtask

    task automatic t_fill_and_drain();
        for (int i = 0; i < 8; i++) begin
            write_pair(lval(i), rval(i));
            @(negedge clk);
            check("R2 empty", 32'(st_empty), 0);
            check("R2 half", 32'(st_half), 32'(i + 1 <= 4));
            check("R2 full", 32'(st_full), 32'(i + 1 == 8));
        end
        write_pair(16'hDEAD, 16'hBEEF);
        @(negedge clk);
        check("R3 overflow set", 32'(st_overflow), 1);
        check("R3 still full", 32'(st_full), 1);
        rx_clear();
        step();
        enable = 1'b1;
        wait_pairs(9, "R6");
        for (int i = 0; i < 8; i++) begin
            check("R6/R5 left order", 32'(pl[i]), 32'(lval(i)));
            check("R6/R5 right order", 32'(pr[i]), 32'(rval(i)));
        end
        check("R8 replay left", 32'(pl[8]), 32'(lval(7)));
        check("R8 replay right", 32'(pr[8]), 32'(rval(7)));
        check("R3 dropped pair absent", 32'(pl[8] != 16'hDEAD), 1);
        @(negedge clk);
        check("R8 underflow", 32'(st_underflow), 1);
        check("R2 drained empty", 32'(st_empty), 1);
        check("R4 bit period", 32'(bad_per), 0);
        check("R4 periods seen", 32'(n_per > 100), 1);
        step();
        enable = 1'b0;
        step();
        @(negedge clk);
        check("R3 overflow sticky", 32'(st_overflow), 1);
    endtask

    task automatic t_reenable_recover();
        int base;
        int guard = 0;
        rx_clear();
        enable = 1'b1;
        while (!st_underflow && guard < 5000) begin
            step();
            guard++;
        end
        base = np;
        write_pair(16'h1234, 16'hABCD);
        @(negedge clk);
        check("R9 write clears underflow", 32'(st_underflow), 0);
        wait_pairs(base + 3, "R9");
        check("R10 replay left", 32'(pl[0]), 32'(lval(7)));
        check("R10 replay right", 32'(pr[0]), 32'(rval(7)));
        check("R8 held pair again", 32'(pl[base + 1]), 32'(lval(7)));
        check("R9 new left", 32'(pl[base + 2]), 32'h1234);
        check("R9 new right", 32'(pr[base + 2]), 32'hABCD);
        step();
        enable = 1'b0;
        step();
        @(negedge clk);
        check("R9 off clears underflow", 32'(st_underflow), 0);
    endtask

    initial begin
        #200_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) step();
        t_reset();
        rst = 1'b0;
        step();
        t_reset();
        t_zero_start();
        t_fill_and_drain();
        t_reenable_recover();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule